// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a small programmable logic device. It receives the OR-array result for its pin, an output-enable product term, a global asynchronous-clear term and a global synchronous-set term. Two configuration bits choose between a registered path through a D flip-flop and a direct combinational path. They also choose whether the pin shows the value as it is or inverted. The cell drives a tri-state pin, given as a data bit and an enable bit. It also returns a feedback bit to the logic array.

The configuration decides more than the pin level. In registered mode the driver is always on, and feedback is taken from the flip-flop, so the pin is output-only. In combinational mode the enable term turns the driver on and off while the device runs, and feedback is taken from the pin itself, so the pin can act as an input. A power-on reset clears the flip-flop. A preload strobe lets a test place any value in the flip-flop directly.

Top module: `out_macrocell`

## Requirements
- R1: `cfgMode`=1 selects registered mode and `cfgMode`=0 selects combinational mode. `cfgPol`=1 shows the value at the pin unchanged and `cfgPol`=0 shows it inverted.
- R2: In registered mode the flip-flop captures `sumIn` on each rising `clk` edge when neither preload nor set is active. `pinOut` then shows the flip-flop value with the selected polarity.
- R3: In registered mode `pinOe` is always 1 and `fbOut` equals the flip-flop value, whatever level `pinIn` carries.
- R4: In combinational mode `pinOut` follows `sumIn` with the selected polarity in the same cycle, with no clock edge needed.
- R5: In combinational mode `pinOe` equals `oeTerm`, and `fbOut` equals `pinIn`.
- R6: `arTerm`=1 clears the flip-flop to 0 at once, without a clock edge. The pin then shows 0 in true polarity and 1 in inverted polarity.
- R7: `spTerm`=1 sets the flip-flop to 1 on a rising edge. While `arTerm` is active, the flip-flop stays at 0 even if `spTerm` is 1.
- R8: While `porN` is 0 the flip-flop is held at 0, asynchronously.
- R9: `preloadStrobe`=1 loads `preloadData` into the flip-flop on a rising edge, overriding both `spTerm` and `sumIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| sumIn | input | 1 | OR-array result for this cell |
| oeTerm | input | 1 | Output-enable product term (combinational mode) |
| arTerm | input | 1 | Global asynchronous-clear term |
| spTerm | input | 1 | Global synchronous-set term |
| cfgMode | input | 1 | 1 = registered, 0 = combinational |
| cfgPol | input | 1 | 1 = true polarity, 0 = inverted |
| preloadStrobe | input | 1 | Test preload strobe |
| preloadData | input | 1 | Value loaded by the preload strobe |
| pinIn | input | 1 | Level currently on the pin |
| pinOut | output | 1 | Pin drive data |
| pinOe | output | 1 | Pin driver enable |
| fbOut | output | 1 | Feedback to the logic array |

## Verification
The bench sweeps every combination of mode, polarity, sum, enable and external pin level. It drives the pin away from the cell while the driver is off. A cell that took feedback from the wrong source would then show the external level in registered mode, or the internal value in combinational mode. Clear is checked between clock edges and with both polarities. A clear that waited for a clock, or one that forced the pin level instead of Q, would show the wrong level in inverted mode. Preload, set and clear are applied together so that each priority decides the outcome. A wrong ordering leaves a flip-flop value that disagrees with the model.

// File: rtl/omc_pkg.sv
package omc_pkg;
  // Strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic clrAsync;  // hold the flip-flop at zero now
    logic loadPre;   // take the preload bit on the next edge
    logic setSync;   // force a one on the next edge
    logic regMode;   // registered path selected
    logic polTrue;   // pin shows the value unchanged
  } omcStrobes_t;
endpackage

// File: rtl/omc_ctrl.sv
module omc_ctrl
  import omc_pkg::*;
(
  input  logic        porN,
  input  logic        arTerm,
  input  logic        spTerm,
  input  logic        preloadStrobe,
  input  logic        cfgMode,
  input  logic        cfgPol,
  output omcStrobes_t strb
);
  // Priority: clear (async) > preload > set > normal capture
  always_comb begin
    strb.clrAsync = !porN || arTerm;
    strb.loadPre  = preloadStrobe;
    strb.setSync  = spTerm && !preloadStrobe;
    strb.regMode  = cfgMode;
    strb.polTrue  = cfgPol;
  end
endmodule

// File: rtl/omc_datapath.sv
module omc_datapath
  import omc_pkg::*;
#(
  parameter logic SET_VALUE = 1'b1
) (
  input  logic        clk,
  input  omcStrobes_t strb,
  input  logic        sumIn,
  input  logic        oeTerm,
  input  logic        preloadData,
  input  logic        pinIn,
  output logic        pinOut,
  output logic        pinOe,
  output logic        fbOut
);
  logic qReg;
  logic srcVal;

  always_ff @(posedge clk or posedge strb.clrAsync) begin
    if (strb.clrAsync)      qReg <= 1'b0;
    else if (strb.loadPre)  qReg <= preloadData;
    else if (strb.setSync)  qReg <= SET_VALUE;
    else                    qReg <= sumIn;
  end

  always_comb begin
    srcVal = strb.regMode ? qReg : sumIn;
    pinOut = strb.polTrue ? srcVal : ~srcVal;
    pinOe  = strb.regMode ? 1'b1 : oeTerm;
    fbOut  = strb.regMode ? qReg : pinIn;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (strb.clrAsync)
    (!strb.loadPre && !strb.setSync) |=> (qReg == $past(sumIn)));
  p_set_r7: assert property (@(posedge clk) disable iff (strb.clrAsync)
    strb.setSync |=> (qReg == SET_VALUE));
  p_preload_r9: assert property (@(posedge clk) disable iff (strb.clrAsync)
    strb.loadPre |=> (qReg == $past(preloadData)));
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import omc_pkg::*;
(
  input  logic clk,
  input  logic porN,
  input  logic sumIn,
  input  logic oeTerm,
  input  logic arTerm,
  input  logic spTerm,
  input  logic cfgMode,
  input  logic cfgPol,
  input  logic preloadStrobe,
  input  logic preloadData,
  input  logic pinIn,
  output logic pinOut,
  output logic pinOe,
  output logic fbOut
);
  omcStrobes_t strb;

  omc_ctrl u_ctrl (
    .porN(porN), .arTerm(arTerm), .spTerm(spTerm),
    .preloadStrobe(preloadStrobe), .cfgMode(cfgMode), .cfgPol(cfgPol),
    .strb(strb)
  );

  omc_datapath u_dp (
    .clk(clk), .strb(strb), .sumIn(sumIn), .oeTerm(oeTerm),
    .preloadData(preloadData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  p_reg_drive_r3: assert property (@(posedge clk) disable iff (!porN)
    cfgMode |-> pinOe);
  p_comb_fb_r5: assert property (@(posedge clk) disable iff (!porN)
    !cfgMode |-> (fbOut == pinIn));
  p_polarity_r1: assert property (@(posedge clk) disable iff (!porN)
    cfgMode |-> (pinOut == (cfgPol ? fbOut : ~fbOut)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!porN)
    (cfgMode && arTerm) |-> (fbOut == 1'b0));
endmodule

// File: tb/sim_out_macrocell.sv
`timescale 1ns/1ps
module sim_out_macrocell;
  logic clk = 0;
  logic porN, sumIn, oeTerm, arTerm, spTerm, cfgMode, cfgPol;
  logic preloadStrobe, preloadData, extDrv;
  logic pinIn, pinOut, pinOe, fbOut;
  logic mq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign pinIn = pinOe ? pinOut : extDrv;

  out_macrocell u0 (
    .clk(clk), .porN(porN), .sumIn(sumIn), .oeTerm(oeTerm), .arTerm(arTerm),
    .spTerm(spTerm), .cfgMode(cfgMode), .cfgPol(cfgPol),
    .preloadStrobe(preloadStrobe), .preloadData(preloadData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, model the edge, sample 1 ns after the edge
  task automatic tick(input logic s, input logic sp, input logic pl, input logic pd);
    @(negedge clk);
    sumIn = s; spTerm = sp; preloadStrobe = pl; preloadData = pd;
    @(posedge clk);
    if (porN && !arTerm) mq = pl ? pd : (sp ? 1'b1 : s);
    #1;
  endtask

  task automatic chkReg(input string req);
    chk({req, " fb"}, fbOut, mq);
    chk({req, " pin"}, pinOut, cfgPol ? mq : ~mq);
    chk({req, " oe"}, pinOe, 1'b1);
  endtask

  initial begin
    porN = 0; sumIn = 0; oeTerm = 0; arTerm = 0; spTerm = 0;
    cfgMode = 1; cfgPol = 1; preloadStrobe = 0; preloadData = 0; extDrv = 0;
    mq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8: power-on reset holds Q low
    chk("R8 reset fb", fbOut, 1'b0);
    chk("R8 reset pin true", pinOut, 1'b0);
    cfgPol = 0; #1;
    chk("R8 reset pin inverted", pinOut, 1'b1);
    @(negedge clk); porN = 1;

    // R4/R5/R1: combinational sweep
    cfgMode = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cfgPol = i[0]; sumIn = i[1]; oeTerm = i[2]; extDrv = i[3];
      #1;
      chk("R4 comb pin", pinOut, cfgPol ? sumIn : ~sumIn);
      chk("R5 comb oe", pinOe, oeTerm);
      chk("R5 comb fb", fbOut, oeTerm ? (cfgPol ? sumIn : ~sumIn) : extDrv);
    end

    // R2/R3/R1: registered sweep, external level fights the pin
    cfgMode = 1; oeTerm = 0;
    for (int p = 0; p < 2; p++) begin
      cfgPol = p[0];
      for (int k = 0; k < 8; k++) begin
        extDrv = ~k[0];
        tick(8'b1011_0010 >> k, 1'b0, 1'b0, 1'b0);
        chkReg("R2 R3 registered");
      end
    end

    // R2: no change between edges
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); sumIn = 0; #1;
    chk("R2 hold between edges", fbOut, 1'b1);

    // R7: set wins over sum
    cfgPol = 1;
    tick(1'b0, 1'b1, 1'b0, 1'b0);
    chkReg("R7 set");
    // R9: preload beats set and sum
    tick(1'b1, 1'b1, 1'b1, 1'b0);
    chkReg("R9 preload 0");
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    chkReg("R9 preload 1");

    // R6: async clear between edges, both polarities
    for (int p = 0; p < 2; p++) begin
      cfgPol = p[0];
      tick(1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk); arTerm = 1; #1;
      mq = 0;
      chk("R6 clear fb", fbOut, 1'b0);
      chk("R6 clear pin", pinOut, cfgPol ? 1'b0 : 1'b1);
      // R7: set with clear active stays 0
      tick(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R7 clear over set", fbOut, 1'b0);
      @(negedge clk); arTerm = 0;
    end

    // R8: reset asserted mid-run
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chkReg("R2 before reset");
    @(negedge clk); porN = 0; #1;
    chk("R8 mid-run reset", fbOut, 1'b0);
    @(negedge clk); porN = 1; mq = 0;
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    chkReg("R8 recover");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule